// File: doc/BRIEF.md
# Asynchronous Parallel Memory Read Controller

This block sits between a synchronous host and an asynchronous read-only memory with a 16-bit data bus and a 17-bit word address. When the host asks for a word, the controller puts the address on the memory pins and pulls the active-low chip enable down. It lowers the active-low output enable late enough that the output-enable access ends in the same cycle as the address access. It then samples the data pins and hands the word back with a one-cycle acknowledge.

Every analog timing figure is a parameter in nanoseconds. The figures are the address and chip-enable access time, the output-enable access time and the output-float time. Each is turned into a whole number of clock cycles by rounding up against the clock-period parameter, so a slower speed grade is only a different set of parameters. After the last word of a burst, both enables rise together. The controller then holds `busFree` low for the float interval, because the memory may still be driving the data pins during that time. Another driver of the shared data bus may be enabled only while `busFree` is high.

If `req` is high during the acknowledge cycle, the host is asking for the next word. The controller then keeps both enables low and changes only the address. Each further word costs one full address access plus the acknowledge cycle.

Top module: `async_rom_reader`

## Requirements
- R1: While `rstN` is low, `memCeN` and `memOeN` are 1, `ack` is 0, `busFree` is 1 and `rdata` is 0.
- R2: `ack` is high for exactly one cycle per word. In that cycle `rdata` holds the memory word stored at the address taken with the request, and `rdata` keeps that value until the next acknowledge.
- R3: A request seen while idle is taken at the next rising clock edge. At that edge `memAddr` takes `addr` and `memCeN` goes to 0. `ack` rises A edges later, where A = ceil(T_ADDR_NS / CLK_PERIOD_NS), so chip enable is low for A cycles before the acknowledge cycle.
- R4: `memOeN` goes low so that it has been low for exactly O cycles when the word is sampled, where O = ceil(T_OE_NS / CLK_PERIOD_NS). `memOeN` is never low while `memCeN` is high.
- R5: Once a word's address has been taken, `memAddr` does not change until that word's acknowledge cycle has ended, whatever `addr` does in the meantime.
- R6: If `req` is high during the acknowledge cycle, the edge that ends that cycle loads the new `addr`. `memCeN` stays low across the boundary, and the next `ack` comes A edges after that load.
- R7: If `req` is low during the acknowledge cycle, `memCeN` and `memOeN` rise together at the edge that ends that cycle. `busFree` then stays low for F cycles, where F = ceil(T_FLOAT_NS / CLK_PERIOD_NS). A request made in this window is not taken until `busFree` is high again.
- R8: `busFree` is high only while both enables are high. It never rises while the memory may still be driving its data pins.
- R9: While idle with `req` low, changes on `addr` leave the enables high and `ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host read request, sampled while idle and in the acknowledge cycle |
| addr | input | 17 | Host word address |
| ack | output | 1 | One-cycle pulse marking a valid `rdata` |
| rdata | output | 16 | Captured memory word |
| busFree | output | 1 | High when the memory data pins are certainly undriven |
| memAddr | output | 17 | Address pins of the memory |
| memCeN | output | 1 | Active-low chip enable |
| memOeN | output | 1 | Active-low output enable |
| memData | input | 16 | Data pins of the memory |

## Verification
Two events meet at one clock edge. The acknowledge cycle closes a word, and a new request either starts the next word or is missed while the enables are released. The bench produces both sides of this. In one case it keeps `req` high and changes `addr` during the acknowledge cycle. In the other it drops `req` and raises it again inside the float window. A timed memory model returns a corrupted word whenever any access window is short, or while it is still driving after release. A streamed read is judged by the word values, by `memCeN` staying low and by the latency of A+1 negedges per word. A late request is judged by chip enable staying high until `busFree` has been high for a cycle, and by `busFree` never being high while the model drives.

// File: rtl/async_rom_pkg.sv
package async_rom_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_ACK     = 2'd2,
    ST_RELEASE = 2'd3
  } rom_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadAddr;
    logic capture;
  } rom_strobe_t;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/rom_read_datapath.sv
module rom_read_datapath
  import async_rom_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rom_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] rdata
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      rdata   <= '0;
    end else begin
      if (strobe.loadAddr) memAddr <= addr;
      if (strobe.capture)  rdata   <= memData;
    end
  end

  // R2: captured word held between captures
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rdata));
endmodule

// File: rtl/rom_read_fsm.sv
module rom_read_fsm
  import async_rom_pkg::*;
#(
  parameter int A_CYC = 3,
  parameter int O_CYC = 1,
  parameter int F_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  output rom_strobe_t strobe,
  output logic        ceN,
  output logic        oeN,
  output logic        ack,
  output logic        busFree
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OE_LEAD = (A_CYC > O_CYC) ? (A_CYC - O_CYC) : 0;
  localparam int MAX_C   = (A_CYC > F_CYC) ? A_CYC : F_CYC;
  localparam int CNT_W   = $clog2(MAX_C + 2);
  localparam logic [CNT_W-1:0] A_LIM    = CNT_W'(A_CYC);
  localparam logic [CNT_W-1:0] O_LIM    = CNT_W'(O_CYC);
  localparam logic [CNT_W-1:0] F_LIM    = CNT_W'(F_CYC);
  localparam logic [CNT_W-1:0] LEAD_LIM = CNT_W'(OE_LEAD);

  rom_state_t       state;
  logic [CNT_W-1:0] addrCnt;
  logic [CNT_W-1:0] oeCnt;
  logic [CNT_W-1:0] relCnt;
  logic             take;
  logic             ready;

  assign take    = req && (state == ST_IDLE || state == ST_ACK);
  assign ready   = (state == ST_ACCESS) && (addrCnt >= A_LIM) && (oeCnt >= O_LIM);
  assign busFree = (state == ST_IDLE);

  always_comb begin
    strobe.loadAddr = take;
    strobe.capture  = ready;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ceN     <= 1'b1;
      oeN     <= 1'b1;
      ack     <= 1'b0;
      addrCnt <= '0;
      oeCnt   <= '0;
      relCnt  <= '0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            state   <= ST_ACCESS;
            ceN     <= 1'b0;
            addrCnt <= CNT_W'(1);
            if (OE_LEAD == 0) begin
              oeN   <= 1'b0;
              oeCnt <= CNT_W'(1);
            end
          end
        end
        ST_ACCESS: begin
          if (ready) begin
            ack   <= 1'b1;
            state <= ST_ACK;
          end else begin
            if (addrCnt < A_LIM) addrCnt <= addrCnt + 1'b1;
            if (oeN && addrCnt >= LEAD_LIM) begin
              oeN   <= 1'b0;
              oeCnt <= CNT_W'(1);
            end else if (!oeN && oeCnt < O_LIM) begin
              oeCnt <= oeCnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (take) begin
            state   <= ST_ACCESS;
            addrCnt <= CNT_W'(1);
          end else begin
            state  <= ST_RELEASE;
            ceN    <= 1'b1;
            oeN    <= 1'b1;
            oeCnt  <= '0;
            relCnt <= CNT_W'(1);
          end
        end
        default: begin
          if (relCnt >= F_LIM) state <= ST_IDLE;
          else                 relCnt <= relCnt + 1'b1;
        end
      endcase
    end
  end

  // R2: a single-cycle acknowledge
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
  // R4: output enable only inside chip enable
  a_r4_oe_in_ce: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !ceN);
endmodule

// File: rtl/async_rom_reader.sv
module async_rom_reader
  import async_rom_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ADDR_NS     = 55,
  parameter int T_OE_NS       = 20,
  parameter int T_FLOAT_NS    = 20,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              busFree,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int A_CYC = nsToCycles(T_ADDR_NS, CLK_PERIOD_NS);
  localparam int O_RAW = nsToCycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int O_CYC = (O_RAW > A_CYC) ? A_CYC : O_RAW;
  localparam int F_CYC = nsToCycles(T_FLOAT_NS, CLK_PERIOD_NS);

  rom_strobe_t strobe;

  rom_read_fsm #(.A_CYC(A_CYC), .O_CYC(O_CYC), .F_CYC(F_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .req(req), .strobe(strobe),
    .ceN(memCeN), .oeN(memOeN), .ack(ack), .busFree(busFree)
  );

  rom_read_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .memData(memData), .memAddr(memAddr), .rdata(rdata)
  );

  // R8: bus offered to others only with the memory disabled
  a_r8_free_idle: assert property (@(posedge clk) disable iff (!rstN)
    busFree |-> (memCeN && memOeN));
  // R7: both enables rise in the same cycle
  a_r7_rise_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> memOeN);
  // R7: no handover in the cycle the enables rise
  a_r7_guard: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> !busFree);
  // R5: address frozen inside one word
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN) && !$past(ack)) |-> $stable(memAddr));
endmodule

// File: tb/async_rom_reader_test.sv
module async_rom_reader_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int P  = 20;
  localparam int TA = 55;
  localparam int TO = 20;
  localparam int TF = 20;
  localparam int A_EXP = (TA + P - 1) / P;
  localparam int O_EXP = (TO + P - 1) / P;
  localparam int F_EXP = (TF + P - 1) / P;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [16:0] addr = '0;
  logic        ack;
  logic [15:0] rdata;
  logic        busFree;
  logic [16:0] memAddr;
  logic        memCeN;
  logic        memOeN;
  logic [15:0] memData = '0;

  int nChecks = 0;
  int nFail = 0;
  int nOverlap = 0;

  async_rom_reader #(.CLK_PERIOD_NS(P), .T_ADDR_NS(TA), .T_OE_NS(TO),
                     .T_FLOAT_NS(TF)) uut (
    .clk(clk), .rstN(rstN), .req(req), .addr(addr), .ack(ack),
    .rdata(rdata), .busFree(busFree), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memData(memData)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] romWord(input logic [16:0] a);
    logic [31:0] w;
    w = (32'(a) * 32'd40503) ^ (32'(a) >> 5);
    return w[15:0] ^ w[31:16];
  endfunction

  // timed memory model
  real tAddr = -1000.0;
  real tCe   = -1000.0;
  real tOe   = -1000.0;
  real tOff  = -1000.0;
  logic romDrive = 1'b0;

  always @(memAddr) tAddr = $realtime;
  always @(negedge memCeN) tCe = $realtime;
  always @(negedge memOeN) tOe = $realtime;
  always @(posedge memCeN or posedge memOeN) tOff = $realtime;

  initial begin
    #0.5;
    forever begin
      real now;
      logic ok;
      now = $realtime + 0.5;
      ok = !memCeN && !memOeN && (now - tAddr >= TA) &&
           (now - tCe >= TA) && (now - tOe >= TO);
      memData  = ok ? romWord(memAddr) : ~romWord(memAddr);
      romDrive = (!memCeN && !memOeN) || (now - tOff < TF);
      #1;
    end
  end

  always @(negedge clk) if (rstN && busFree && romDrive) nOverlap++;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitFree();
    int relLow = 0;
    bit bad = 0;
    while (!busFree && relLow < 100) begin
      if (!memCeN || !memOeN || ack) bad = 1;
      relLow++;
      @(negedge clk);
    end
    check(relLow == F_EXP, "R7 release cycles", relLow, F_EXP);
    check(!bad, "R7 enables high and ack low in release", bad, 0);
  endtask

  task automatic singleRead(input logic [16:0] a, input bit disturb);
    int waitN = 0;
    int ceLow = 0;
    int oeLow = 0;
    bit moved = 0;
    @(negedge clk);
    req = 1'b1;
    addr = a;
    forever begin
      @(negedge clk);
      waitN++;
      if (ack || waitN > 100) break;
      if (!memCeN) ceLow++;
      if (!memOeN) oeLow++;
      if (memAddr != a) moved = 1;
      if (disturb) addr = ~a;
    end
    req = 1'b0;
    check(waitN == A_EXP + 1, "R3 ack latency", waitN, A_EXP + 1);
    check(ceLow == A_EXP, "R3 chip enable cycles", ceLow, A_EXP);
    check(oeLow == O_EXP, "R4 output enable cycles", oeLow, O_EXP);
    check(rdata == romWord(a), "R2 word value", rdata, romWord(a));
    check(!moved, "R5 address held", memAddr, a);
    @(negedge clk);
    check(!ack, "R2 ack one cycle", ack, 0);
    check(rdata == romWord(a), "R2 word held", rdata, romWord(a));
    waitFree();
  endtask

  task automatic streamRead(input logic [16:0] base, input int n);
    bit ceRose = 0;
    @(negedge clk);
    req = 1'b1;
    addr = base;
    for (int i = 0; i < n; i++) begin
      int waitN = 0;
      forever begin
        @(negedge clk);
        waitN++;
        if (ack || waitN > 100) break;
        if (memCeN && i > 0) ceRose = 1;
      end
      check(waitN == A_EXP + 1, "R6 stream latency", waitN, A_EXP + 1);
      check(rdata == romWord(base + 17'(i)), "R6 stream word", rdata,
            romWord(base + 17'(i)));
      if (i < n - 1) addr = base + 17'(i + 1);
      else req = 1'b0;
    end
    check(!ceRose, "R6 chip enable kept low", ceRose, 0);
    @(negedge clk);
    waitFree();
  endtask

  task automatic lateRequest(input logic [16:0] a, input logic [16:0] b);
    int waitN = 0;
    bit early = 0;
    @(negedge clk);
    req = 1'b1;
    addr = a;
    while (!ack && waitN < 100) begin
      @(negedge clk);
      waitN++;
    end
    req = 1'b0;
    @(negedge clk);
    req = 1'b1;
    addr = b;
    while (!busFree && waitN < 200) begin
      if (!memCeN) early = 1;
      @(negedge clk);
      waitN++;
    end
    check(!early, "R7 request held during release", early, 0);
    while (!ack && waitN < 300) begin
      @(negedge clk);
      waitN++;
    end
    req = 1'b0;
    check(rdata == romWord(b), "R7 late request served", rdata, romWord(b));
    @(negedge clk);
    waitFree();
  endtask

  task automatic finishRun();
    check(nOverlap == 0, "R8 bus free while memory drives", nOverlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(P * 150000);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN && memOeN, "R1 enables high in reset", {memCeN, memOeN}, 3);
    check(!ack && busFree, "R1 ack low and bus free in reset",
          {ack, busFree}, 1);
    check(rdata == 16'h0, "R1 rdata cleared", rdata, 0);
    rstN = 1'b1;
    // R9: idle, addr wiggles, no request
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr = 17'(i * 9731);
      check(memCeN && memOeN && !ack, "R9 idle ignores addr",
            {memCeN, memOeN, ack}, 6);
    end
    for (int i = 0; i < 32; i++) singleRead(17'(i), 1'b0);
    for (int i = 0; i < 32; i++) singleRead(17'h1FFE0 + 17'(i), i[0]);
    streamRead(17'h0A5A0, 16);
    streamRead(17'h1FFFC, 4);
    lateRequest(17'h00123, 17'h10321);
    lateRequest(17'h1FFFF, 17'h00000);
    finishRun();
  end
endmodule